// File: doc/BRIEF.md
# Pseudo-Carry Lookahead Adder

This block adds two unsigned operands and a carry input, and returns the sum together with the carry out. Inside, it never passes the ordinary carry from bit to bit. It passes a pseudo-carry instead, which obeys a shorter recurrence. The real carry into a bit is rebuilt only at that bit's sum gate, by ANDing the pseudo-carry with the transfer signal of the bit below.

Each bit forms a generate signal (both inputs high), a transfer signal (either input high) and a half-sum (the inputs differ). Every group of four bits turns these into a group pseudo-carry term and a group transfer term. Because a generate always implies its own transfer, the group pseudo-carry term needs no gate wider than four inputs. A flat sum-of-products lookahead then combines the group terms into the pseudo-carry at every group boundary, with the carry input as the pseudo-carry at position zero. The width is a parameter and must be a multiple of four. The default is 32, and 64 is also supported.

The operands arrive on a valid/ready input stream, and the result leaves on a valid/ready output stream. With the output register enabled (the default), a one-entry slot holds the result. The upstream side may present a new pair in the same cycle that the downstream side takes the current result. While a result is held and not taken, the input is refused, and the held result does not change. With the register disabled, the adder is purely combinational: valid and ready pass straight through.

Top module: `ling_adder`

## Requirements
- R1: In the cycle after a pair is accepted, `sum` equals the low WIDTH bits of op_a + op_b + carry_in.
- R2: In the cycle after a pair is accepted, `carry_out` equals bit WIDTH of op_a + op_b + carry_in.
- R3: A carry that ripples through the whole width gives a zero sum and carry_out = 1. Two such cases are all-ones plus zero with carry_in = 1, and alternating 0101… plus 1010… with carry_in = 1.
- R4: Zero plus zero gives sum 0 and carry_out 0 when carry_in = 0, and sum 1 and carry_out 0 when carry_in = 1. All-ones plus all-ones with carry_in = 1 gives sum all-ones and carry_out 1.
- R5: A pair is accepted when in_valid and in_ready are both high at a clock edge. `out_valid` is high in the following cycle.
- R6: While out_valid is high and out_ready is low, out_valid stays high, and sum and carry_out hold their values.
- R7: in_ready is high whenever no result is held, or whenever out_ready is high.
- R8: During reset and right after it, out_valid is low and in_ready is high.
- R9: A pair offered while in_ready is low is not taken. The held result is still on the outputs after such offers. When out_ready rises, that pending pair is accepted and its result appears in the next cycle.
- R10: R1 to R4 hold for both a 32-bit and a 64-bit instance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output slot |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | An operand pair is present |
| in_ready | output | 1 | The adder takes the pair at this edge |
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| out_valid | output | 1 | A result is held on sum/carry_out |
| out_ready | input | 1 | Downstream takes the result at this edge |
| sum | output | WIDTH | Low WIDTH bits of the total |
| carry_out | output | 1 | Carry out of the top bit |

## Verification
The properties check on every cycle that each accepted pair returns its arithmetic total one cycle later. They also check that a stalled result neither drops nor changes, that ready follows the slot state, and that reset empties the slot. The directed scenarios are needed for the specific carry chains: full-width ripple from the carry input, alternating patterns and the all-ones cases. They are also needed to show that a pair offered during a stall is left untouched and is accepted once the stall clears, and that the 64-bit instance agrees with the 32-bit one.

// File: rtl/ling_pkg.sv
package ling_pkg;
  localparam int GRP = 4;

  // One group's contribution to the lookahead: pseudo-carry term and transfer term
  typedef struct packed {
    logic hg;
    logic tg;
  } grp_term_t;
endpackage

// File: rtl/ling_bitcells.sv
module ling_bitcells #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] g,
  output logic [W-1:0] t,
  output logic [W-1:0] d
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign g[i] = a[i] & b[i];
    assign t[i] = a[i] | b[i];
    assign d[i] = a[i] ^ b[i];
  end
endmodule

// File: rtl/ling_group.sv
module ling_group
  import ling_pkg::*;
(
  input  logic [3:0] g,       // generates of bits j..j+3
  input  logic [2:0] t,       // transfers of bits j..j+2
  input  logic       t_prev,  // transfer of bit j-1 (1 for the lowest group)
  input  logic       h_in,    // pseudo-carry into bit j
  output grp_term_t  term,
  output logic [3:0] h        // pseudo-carries into bits j..j+3
);
  // A generate implies its own transfer, so t_k & g_k folds to g_k
  assign term.hg = g[3] | g[2] | (t[2] & g[1]) | (t[2] & t[1] & g[0]);
  assign term.tg = t[2] & t[1] & t[0] & t_prev;

  assign h[0] = h_in;
  assign h[1] = g[0] | (t_prev & h_in);
  assign h[2] = g[1] | g[0] | (t[0] & t_prev & h_in);
  assign h[3] = g[2] | g[1] | (t[1] & g[0]) | (t[1] & t[0] & t_prev & h_in);
endmodule

// File: rtl/ling_lookahead.sv
module ling_lookahead
  import ling_pkg::*;
#(
  parameter int NG = 8
) (
  input  grp_term_t       terms [NG],
  input  logic            cin,
  output logic [NG:0]     hb          // pseudo-carry at each group boundary
);
  // Flat sum of products: each boundary is an OR of terms, none chained on another
  always_comb begin
    logic acc;
    logic prod;
    hb[0] = cin;
    for (int m = 0; m < NG; m++) begin
      acc  = 1'b0;
      prod = 1'b1;
      for (int k = m; k >= 0; k--) begin
        acc  = acc | (terms[k].hg & prod);
        prod = prod & terms[k].tg;
      end
      hb[m+1] = acc | (cin & prod);
    end
  end
endmodule

// File: rtl/ling_core.sv
module ling_core
  import ling_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] s,
  output logic         cout
);
  localparam int NG = W / GRP;

  logic [W-1:0] g, t, d, tprev, h;
  logic [NG:0]  hb;
  grp_term_t    terms [NG];

  ling_bitcells #(.W(W)) u_bits (.a(a), .b(b), .g(g), .t(t), .d(d));

  assign tprev = {t[W-2:0], 1'b1};

  for (genvar gi = 0; gi < NG; gi++) begin : g_grp
    ling_group u_grp (
      .g      (g[GRP*gi +: 4]),
      .t      (t[GRP*gi +: 3]),
      .t_prev (tprev[GRP*gi]),
      .h_in   (hb[gi]),
      .term   (terms[gi]),
      .h      (h[GRP*gi +: 4])
    );
  end

  ling_lookahead #(.NG(NG)) u_la (.terms(terms), .cin(cin), .hb(hb));

  // Real carry into bit i is tprev[i] & h[i]; it is formed only here
  assign s    = d ^ (tprev & h);
  assign cout = t[W-1] & hb[NG];
endmodule

// File: rtl/ling_adder.sv
module ling_adder #(
  parameter int WIDTH   = 32,
  parameter bit REG_OUT = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             carry_in,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [WIDTH-1:0] sum,
  output logic             carry_out
);
  logic [WIDTH-1:0] core_s;
  logic             core_c;

  ling_core #(.W(WIDTH)) u_core (
    .a(op_a), .b(op_b), .cin(carry_in), .s(core_s), .cout(core_c)
  );

  if (REG_OUT) begin : g_reg
    logic             vld_q;
    logic [WIDTH-1:0] s_q;
    logic             c_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q <= 1'b0;
        s_q   <= '0;
        c_q   <= 1'b0;
      end else begin
        if (in_ready) vld_q <= in_valid;
        if (in_valid && in_ready) begin
          s_q <= core_s;
          c_q <= core_c;
        end
      end
    end

    assign in_ready  = !vld_q || out_ready;
    assign out_valid = vld_q;
    assign sum       = s_q;
    assign carry_out = c_q;
  end else begin : g_comb
    assign in_ready  = out_ready;
    assign out_valid = in_valid;
    assign sum       = core_s;
    assign carry_out = core_c;
  end
endmodule

// File: rtl/ling_adder_chk.sv
module ling_adder_chk #(
  parameter int WIDTH   = 32,
  parameter bit REG_OUT = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [WIDTH-1:0] op_a,
  input logic [WIDTH-1:0] op_b,
  input logic             carry_in,
  input logic             out_valid,
  input logic             out_ready,
  input logic [WIDTH-1:0] sum,
  input logic             carry_out
);
  logic [WIDTH:0] ref_tot;
  assign ref_tot = {1'b0, op_a} + {1'b0, op_b} + {{WIDTH{1'b0}}, carry_in};

  if (REG_OUT) begin : g_reg_props
    p_sum_r1: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready |=> sum == $past(ref_tot[WIDTH-1:0]));
    p_cout_r2: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready |=> carry_out == $past(ref_tot[WIDTH]));
    p_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready |=> out_valid);
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(sum) && $stable(carry_out));
    p_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!out_valid || out_ready) |-> in_ready);
    p_idle_r8: assert property (@(posedge clk)
      !rst_n |-> !out_valid && in_ready);
  end else begin : g_comb_props
    p_comb_sum_r1: assert property (@(posedge clk) disable iff (!rst_n)
      {carry_out, sum} == ref_tot);
  end
endmodule

bind ling_adder ling_adder_chk #(.WIDTH(WIDTH), .REG_OUT(REG_OUT)) u_chk (.*);

// File: tb/ling_adder_test.sv
module ling_adder_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, out_ready, cin;
  logic [63:0] a, b;
  logic        rdy32, rdy64, ov32, ov64, co32, co64;
  logic [31:0] s32;
  logic [63:0] s64;
  int          vectors = 0;
  int          fails   = 0;
  int          cyc     = 0;

  always #10 clk = ~clk;  // 50 MHz

  ling_adder #(.WIDTH(32)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy32),
    .op_a(a[31:0]), .op_b(b[31:0]), .carry_in(cin), .out_valid(ov32),
    .out_ready(out_ready), .sum(s32), .carry_out(co32));

  ling_adder #(.WIDTH(64)) uut64 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy64),
    .op_a(a), .op_b(b), .carry_in(cin), .out_valid(ov64),
    .out_ready(out_ready), .sum(s64), .carry_out(co64));

  task automatic check(input string req, input logic [64:0] act, input logic [64:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Compare both widths against plain arithmetic for the operands last accepted
  task automatic compare(input string req, input logic [63:0] xa, input logic [63:0] xb, input logic xc);
    logic [32:0] e32;
    logic [64:0] e64;
    e32 = {1'b0, xa[31:0]} + {1'b0, xb[31:0]} + {32'b0, xc};
    e64 = {1'b0, xa} + {1'b0, xb} + {64'b0, xc};
    check({req, " w32"}, {32'b0, co32, s32}, {32'b0, e32});
    check({req, " w64 R10"}, {co64, s64}, e64);
  endtask

  task automatic apply(input string req, input logic [63:0] xa, input logic [63:0] xb, input logic xc);
    @(negedge clk);
    a = xa; b = xb; cin = xc; in_valid = 1'b1; out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " R5 valid"}, {63'b0, ov32, ov64}, 65'd3);
    compare(req, xa, xb, xc);
  endtask

  task automatic t_reset;
    check("R8 idle", {61'b0, ov32, ov64, rdy32, rdy64}, 65'b0011);
  endtask

  task automatic t_zeros;
    apply("R4 zero cin0", '0, '0, 1'b0);
    apply("R4 zero cin1", '0, '0, 1'b1);
  endtask

  task automatic t_ones;
    apply("R4 ones cin1", '1, '1, 1'b1);
    apply("R1 ones cin0", '1, '1, 1'b0);
  endtask

  task automatic t_ripple;
    apply("R3 ones plus carry", '1, '0, 1'b1);
    apply("R3 alt plus carry", {16{4'h5}}, {16{4'hA}}, 1'b1);
    apply("R1 alt same", {16{4'h5}}, {16{4'h5}}, 1'b0);
    apply("R2 alt high", {16{4'hA}}, {16{4'hA}}, 1'b1);
  endtask

  task automatic t_random;
    for (int i = 0; i < 200; i++) begin
      apply("R1 R2 random", {$urandom, $urandom}, {$urandom, $urandom}, 1'($urandom));
    end
  endtask

  task automatic t_stall;
    logic [63:0] xa, xb, ya, yb;
    xa = 64'h0123_4567_89AB_CDEF; xb = 64'hFEDC_BA98_7654_3210;
    ya = 64'h8000_0000_FFFF_FFFF; yb = 64'h8000_0000_0000_0001;
    @(negedge clk);
    in_valid = 1'b0; out_ready = 1'b1;   // drain the slot
    @(negedge clk);
    a = xa; b = xb; cin = 1'b1; in_valid = 1'b1; out_ready = 1'b0;
    @(negedge clk);
    a = ya; b = yb; cin = 1'b0;          // offered while the slot is full
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R7 R9 refused", {63'b0, rdy32, rdy64}, 65'd0);
      check("R6 held valid", {63'b0, ov32, ov64}, 65'd3);
      compare("R6 R9 held", xa, xb, 1'b1);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    compare("R9 pending taken", ya, yb, 1'b0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      fails++;
      $display("FAIL R5 watchdog: actual %0d cycles expected under 20000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0; cin = 1'b0; a = '0; b = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_zeros();
    t_ones();
    t_ripple();
    t_stall();
    t_random();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule